// File: doc/BRIEF.md
# Serial EEPROM Target with Persistent Word Pointer

This block is an I2C target that models a small serial EEPROM of 256 bytes addressed by a single word-address byte. It is meant as a synthesizable counterpart for exercising a host that reads module configuration data over a two-wire bus. The block watches the open-drain clock and data lines through synchronisers. It detects START, repeated START and STOP, matches its fixed 7-bit device address, and answers writes and reads.

One 8-bit pointer serves both directions and survives from one transaction to the next. In a write transaction the first byte after the device address loads the pointer, and every later byte is stored at the pointer, which then advances. A read streams bytes from the pointer onward, advancing it after each byte, whether or not the reads share one START/STOP frame. The storage can be filled through a parallel load port. A write-protect input blocks stores while keeping the bus protocol and the pointer movement unchanged.

Top module: `i2c_ee_slave`

## Requirements
- R1: The block acknowledges a device byte whose upper seven bits are 7'b1010000. The low bit selects the direction: 0 means write, 1 means read.
- R2: In a write transaction, the first byte after the device byte loads the pointer. If the transaction ends with no further byte, the pointer keeps that value.
- R3: Each later byte of a write transaction is acknowledged and stored at the pointer, and the pointer then advances by one.
- R4: A read begins at the current pointer and advances it by one after each byte sent. The pointer is carried across STOP and new frames.
- R5: The pointer wraps from 8'hFF to 8'h00 on both reads and writes.
- R6: The block changes its SDA drive only while SCL is low. It samples master bits on SCL rising edges.
- R7: A device byte with any other address gets no acknowledge. The block then leaves SDA released and the pointer unchanged until the next START.
- R8: After a sent byte, a master ACK (SDA low) makes the block drive the next byte. A master NACK makes it release SDA and stay silent until STOP or START.
- R9: While `wp` is high, data bytes are acknowledged but not stored. The pointer still loads and advances.
- R10: A cycle with `init_we` high writes `init_data` at `init_addr`. This takes priority over a bus store in the same cycle.
- R11: A START or repeated START in the middle of a byte abandons that byte, with no store and no pointer change, and restarts device-address reception. A STOP returns the block to idle with the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than SCL by several times |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| sda_oe | output | 1 | High pulls the data line low (open drain) |
| wp | input | 1 | Write protect; blocks stores into the array |
| init_we | input | 1 | Parallel load strobe |
| init_addr | input | 8 | Parallel load location |
| init_data | input | 8 | Parallel load value |

## Verification
The hardest condition to reach from the pins is a START that lands partway through a byte. A well-behaved master never produces one, yet it must discard the partial byte without disturbing the pointer or the array. The bench gets there by clocking a handful of raw bits and then issuing a repeated START, both during the device byte and during a data byte. It then reads back to show that neither a store nor a pointer step took place. Pointer persistence across frames is shown with reads that follow earlier transactions and issue no address write of their own.

// File: rtl/i2c_ee_pkg.sv
// Package: shared types for the serial EEPROM target.
// Assumes: nothing beyond IEEE 1800-2017.
package i2c_ee_pkg;

    // Protocol phases of the target controller.
    typedef enum logic [2:0] {
        ST_IDLE,     // waiting for START
        ST_DEV,      // shifting in the device byte
        ST_DEV_ACK,  // driving ACK for the device byte
        ST_WR,       // shifting in a write byte
        ST_WR_ACK,   // driving ACK for a write byte
        ST_RD,       // shifting out a read byte
        ST_RD_ACK,   // sampling the master ACK/NACK
        ST_WAIT      // silent until START or STOP
    } ee_state_e;

endpackage

// File: rtl/i2c_ee_sync.sv
// Module: i2c_ee_sync
// Synchronises SCL and SDA into the clk domain and derives clock edges
// and START/STOP events from the synchronised copies.
// Assumes: clk runs several times faster than SCL; STAGES >= 2.
module i2c_ee_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Shift both lines through the synchroniser and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    // Edge and condition decode from the synchronised samples.
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/i2c_ee_store.sv
// Module: i2c_ee_store
// Register-array backing store with a combinational read port, a bus
// write port and a parallel load port that wins on a collision.
// Assumes: contents are undefined until loaded; no reset of the array.
module i2c_ee_store #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_we,
    input  logic [AW-1:0] init_addr,
    input  logic [DW-1:0] init_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    // Store a byte: the load port first, then the bus.
    always_ff @(posedge clk) begin
        if (init_we) begin
            mem_q[init_addr] <= init_data;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Read the byte under the pointer.
    assign rd_data = mem_q[rd_addr];

    // R10: a load strobe leaves its value at its location.
    a_r10_init_lands: assert property (@(posedge clk) disable iff (!rst_n)
        init_we |=> mem_q[$past(init_addr)] == $past(init_data));

endmodule

// File: rtl/i2c_ee_ctrl.sv
// Module: i2c_ee_ctrl
// Protocol engine: matches the device byte, runs write and read phases,
// owns the persistent word pointer and the open-drain SDA drive.
// Assumes: edge/condition strobes come from i2c_ee_sync; one bus byte is
// DW bits; the pointer is AW bits and loads from the low bits of a byte.
module i2c_ee_ctrl
    import i2c_ee_pkg::*;
#(
    parameter int         AW       = 8,
    parameter int         DW       = 8,
    parameter logic [6:0] DEV_ADDR = 7'b1010000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          wp,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] ptr,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          sda_oe
);

    localparam int CNT_W = $clog2(DW + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DW);

    ee_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DW-1:0]  sh_q;
    logic [DW-1:0]  tx_q;
    logic           rw_q;
    logic           first_q;
    logic           mack_q;
    logic [AW-1:0]  ptr_q;
    logic           oe_q;
    logic           byte_end;
    logic           ptr_load;

    // Decode the end of a received write byte and what it does.
    always_comb begin
        byte_end = (state_q == ST_WR) && scl_fall && (cnt_q == LAST)
                   && !start_det && !stop_det;
        ptr_load = byte_end && first_q;
        wr_en    = byte_end && !first_q && !wp;
        wr_data  = sh_q;
    end

    assign ptr    = ptr_q;
    assign sda_oe = oe_q;

    // Main protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            tx_q    <= '0;
            rw_q    <= 1'b0;
            first_q <= 1'b0;
            mack_q  <= 1'b0;
            ptr_q   <= '0;
            oe_q    <= 1'b0;
        end else if (start_det) begin
            state_q <= ST_DEV;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
        end else if (stop_det) begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_DEV: begin
                    if (scl_rise) begin
                        sh_q  <= {sh_q[DW-2:0], sda_s};
                        cnt_q <= cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == LAST) begin
                        if (sh_q[DW-1 -: 7] == DEV_ADDR) begin
                            oe_q    <= 1'b1;
                            rw_q    <= sh_q[0];
                            state_q <= ST_DEV_ACK;
                        end else begin
                            state_q <= ST_WAIT;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        cnt_q <= '0;
                        if (rw_q) begin
                            tx_q    <= rd_data;
                            oe_q    <= ~rd_data[DW-1];
                            state_q <= ST_RD;
                        end else begin
                            oe_q    <= 1'b0;
                            first_q <= 1'b1;
                            state_q <= ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise) begin
                        sh_q  <= {sh_q[DW-2:0], sda_s};
                        cnt_q <= cnt_q + 1'b1;
                    end else if (byte_end) begin
                        oe_q    <= 1'b1;
                        first_q <= 1'b0;
                        ptr_q   <= first_q ? AW'(sh_q) : ptr_q + 1'b1;
                        state_q <= ST_WR_ACK;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        oe_q    <= 1'b0;
                        cnt_q   <= '0;
                        state_q <= ST_WR;
                    end
                end
                ST_RD: begin
                    if (scl_rise) begin
                        cnt_q <= cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == LAST) begin
                        oe_q    <= 1'b0;
                        ptr_q   <= ptr_q + 1'b1;
                        state_q <= ST_RD_ACK;
                    end else if (scl_fall && cnt_q != '0) begin
                        tx_q <= tx_q << 1;
                        oe_q <= ~tx_q[DW-2];
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        mack_q <= ~sda_s;
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            tx_q    <= rd_data;
                            oe_q    <= ~rd_data[DW-1];
                            cnt_q   <= '0;
                            state_q <= ST_RD;
                        end else begin
                            state_q <= ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R6: the SDA drive only moves after a cycle with SCL low.
    a_r6_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(oe_q) |-> !$past(scl_s));

    // R7: in the silent state the line is never pulled.
    a_r7_wait_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> !oe_q);

    // R4: apart from a load, the pointer only ever steps by one.
    a_r4_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ptr_q) && !$past(ptr_load)) |-> ptr_q == AW'($past(ptr_q) + 1'b1));

    // R8: a master NACK releases SDA and parks the engine.
    a_r8_nack_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_ACK && scl_fall && !mack_q && !start_det && !stop_det)
            |=> (state_q == ST_WAIT && !oe_q));

    // R11: STOP idles the engine and leaves the pointer alone.
    a_r11_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == ST_IDLE && !oe_q && $stable(ptr_q)));

endmodule

// File: rtl/i2c_ee_slave.sv
// Module: i2c_ee_slave (top)
// Serial EEPROM target: 2^AW bytes of DW bits, single-byte word pointer
// shared by reads and writes, write protect, parallel load port.
// Assumes: external pull-up; sda_oe high pulls SDA low.
module i2c_ee_slave #(
    parameter int         AW          = 8,
    parameter int         DW          = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'b1010000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic          wp,
    input  logic          init_we,
    input  logic [AW-1:0] init_addr,
    input  logic [DW-1:0] init_data
);

    logic          scl_s;
    logic          sda_s;
    logic          scl_rise;
    logic          scl_fall;
    logic          start_det;
    logic          stop_det;
    logic [AW-1:0] ptr;
    logic          wr_en;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;

    i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_ee_store #(.AW(AW), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_we   (init_we),
        .init_addr (init_addr),
        .init_data (init_data),
        .wr_en     (wr_en),
        .wr_addr   (ptr),
        .wr_data   (wr_data),
        .rd_addr   (ptr),
        .rd_data   (rd_data)
    );

    i2c_ee_ctrl #(.AW(AW), .DW(DW), .DEV_ADDR(DEV_ADDR)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .wp        (wp),
        .rd_data   (rd_data),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe)
    );

endmodule

// File: tb/i2c_ee_slave_bench.sv
// Bench for i2c_ee_slave: a bit-level bus master, a reference memory and
// pointer held in the bench, seeded random transfers plus corner cases.
module i2c_ee_slave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;       // clk cycles per quarter SCL bit
    localparam int WD_CYCLES  = 150000;
    localparam logic [7:0] DEV_W = 8'hA0;
    localparam logic [7:0] DEV_R = 8'hA1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       slave_oe;
    logic       wp = 1'b0;
    logic       init_we = 1'b0;
    logic [7:0] init_addr = '0;
    logic [7:0] init_data = '0;

    logic [7:0] ref_mem [256];
    logic [7:0] ref_ptr = '0;
    int         checks = 0;
    int         fails = 0;
    int         r6_bad = 0;
    logic       oe_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = sda_m & ~slave_oe;

    i2c_ee_slave u_i2c_ee_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_oe    (slave_oe),
        .wp        (wp),
        .init_we   (init_we),
        .init_addr (init_addr),
        .init_data (init_data)
    );

    // R6 monitor: any change of the slave drive while SCL is high is counted.
    always @(posedge clk) begin
        oe_prev <= slave_oe;
        if (rst_n && (slave_oe != oe_prev) && scl) r6_bad <= r6_bad + 1;
    end

    function automatic logic [7:0] next_ptr(input logic [7:0] p);
        return p + 8'd1;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_bit(input logic b, output logic seen);
        wait_clk(Q); sda_m = b;
        wait_clk(Q); scl = 1'b1;
        wait_clk(Q); seen = sda_line;
        wait_clk(Q); scl = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl = 1'b1;   wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_clk(Q); sda_m = 1'b0;
        wait_clk(Q); scl = 1'b1;
        wait_clk(Q); sda_m = 1'b1;
        wait_clk(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(d[i], s);
        bus_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            bus_bit(1'b1, s);
            d = {d[6:0], s};
        end
        bus_bit(!mack, s);
    endtask

    // Write transaction: pointer byte then n data bytes (stored unless wp).
    task automatic wr_frame(input logic [7:0] a, input int n, input logic wpv, input string req);
        logic ack;
        logic [7:0] d;
        wp = wpv;
        bus_start();
        send_byte(DEV_W, ack); check(ack, "R1", ack, 1);
        send_byte(a, ack);     check(ack, "R2", ack, 1);
        ref_ptr = a;
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            send_byte(d, ack); check(ack, req, ack, 1);
            if (!wpv) ref_mem[ref_ptr] = d;
            ref_ptr = next_ptr(ref_ptr);
        end
        bus_stop();
        wp = 1'b0;
    endtask

    // Read transaction of n bytes from the current pointer, last one NACKed.
    task automatic rd_frame(input int n, input string req);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte(DEV_R, ack); check(ack, "R1", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, d);
            check(d == ref_mem[ref_ptr], req, d, ref_mem[ref_ptr]);
            ref_ptr = next_ptr(ref_ptr);
        end
        bus_stop();
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        wait_clk(WD_CYCLES);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", WD_CYCLES, 0);
        summary();
        $finish;
    end

    initial begin
        logic ack;
        logic s;
        logic [7:0] d;
        void'($urandom(32'd2024));
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        check(slave_oe == 1'b0, "R6 reset", slave_oe, 0);

        // R10: preload the whole array through the load port.
        for (int i = 0; i < 256; i++) begin
            init_we = 1'b1; init_addr = 8'(i); init_data = 8'($urandom);
            ref_mem[i] = init_data;
            wait_clk(1);
        end
        init_we = 1'b0;
        wait_clk(4);

        // R2/R10/R8: point at 0x10, read four preloaded bytes.
        wr_frame(8'h10, 0, 1'b0, "R2");
        rd_frame(4, "R10");
        // R4: continue across a fresh frame with no pointer write.
        rd_frame(2, "R4");

        // R3: seeded random write bursts, read back from the start point.
        for (int it = 0; it < 12; it++) begin
            logic [7:0] a;
            int n;
            a = 8'($urandom);
            n = 1 + int'($urandom % 6);
            wr_frame(a, n, 1'b0, "R3");
            wr_frame(a, 0, 1'b0, "R2");
            rd_frame(n, "R3");
        end

        // R5: write across the top of the array, then read across it.
        wr_frame(8'hFE, 3, 1'b0, "R5");
        rd_frame(1, "R5");
        wr_frame(8'hFE, 0, 1'b0, "R5");
        rd_frame(3, "R5");

        // R9: protected write is acked, not stored, pointer still advances.
        wr_frame(8'h40, 3, 1'b1, "R9");
        rd_frame(1, "R9");
        wr_frame(8'h40, 0, 1'b0, "R9");
        rd_frame(3, "R9");

        // R7: foreign address gets no ACK, following byte ignored.
        bus_start();
        send_byte(8'hA2, ack); check(!ack, "R7", ack, 0);
        send_byte(8'h00, ack); check(!ack, "R7", ack, 0);
        bus_stop();
        rd_frame(1, "R7");

        // R8: after a NACK the slave keeps SDA released.
        bus_start();
        send_byte(DEV_R, ack); check(ack, "R8", ack, 1);
        recv_byte(1'b0, d);
        check(d == ref_mem[ref_ptr], "R8", d, ref_mem[ref_ptr]);
        ref_ptr = next_ptr(ref_ptr);
        recv_byte(1'b0, d);
        check(d == 8'hFF, "R8 released", d, 8'hFF);
        bus_stop();
        rd_frame(1, "R8");

        // R11: START in the middle of a device byte restarts reception.
        bus_start();
        bus_bit(1'b1, s); bus_bit(1'b0, s); bus_bit(1'b1, s); bus_bit(1'b0, s);
        wr_frame(8'h33, 0, 1'b0, "R11");
        rd_frame(1, "R11");

        // R11: START in the middle of a data byte: no store, pointer kept.
        bus_start();
        send_byte(DEV_W, ack); check(ack, "R11", ack, 1);
        send_byte(8'h50, ack); check(ack, "R11", ack, 1);
        ref_ptr = 8'h50;
        bus_bit(~ref_mem[8'h50][7], s); bus_bit(1'b0, s); bus_bit(1'b1, s);
        bus_start();
        send_byte(DEV_R, ack); check(ack, "R11", ack, 1);
        recv_byte(1'b0, d);
        check(d == ref_mem[8'h50], "R11 abort", d, ref_mem[8'h50]);
        ref_ptr = next_ptr(ref_ptr);
        bus_stop();

        check(r6_bad == 0, "R6", r6_bad, 0);
        summary();
        $finish;
    end

endmodule